// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte mailbox between a PC host bus and the embedded microcontroller of a keyboard controller. The host side works through a chip select, read and write strobes, one address bit and a data byte. A write at address 0 posts a data byte and a write at address 1 posts a command byte. Both go into one input buffer. A status flag records which kind was posted. A host read at address 0 collects the byte the controller left in the output buffer. A host read at address 1 returns the status register.

The controller side reads the input buffer, fills the output buffer, updates the status bits that belong to software, and drives a three-bit control latch. That latch carries a level for the keyboard interrupt, a level for the mouse interrupt, and the address-line-20 gate output. At first the two interrupt outputs simply follow their latch bits. After the controller issues the enable-flags command, the keyboard interrupt becomes "output buffer full" gated by its latch bit. The mouse interrupt becomes "input buffer empty" gated by its latch bit. Enable-flags mode stays on until reset.

All ports sample on the rising clock edge. A strobe is counted once for each cycle in which it is high together with `hst_cs`. Host read data is registered and is valid in the cycle after the read strobe.

Top module: `kbd_host_mailbox`

## Requirements
- R1: A host write with `hst_cs`=1 and `hst_addr`=0 loads `hst_wdata` into the input buffer (seen on `mc_ib_data`), sets status bit 1 (input full) and clears status bit 3 (command flag), from the next cycle on.
- R2: A host write with `hst_addr`=1 does the same as R1 but sets status bit 3 to 1.
- R3: A controller output write (`mc_ob_wr`) stores `mc_ob_wdata` and sets status bit 0 (output full). A later host read at address 0 returns that byte on `hst_rdata` in the next cycle and clears status bit 0.
- R4: A host read at address 1 returns the status register as it stood in the strobe cycle on `hst_rdata` in the next cycle, and it changes no flag. The status layout is: bit 0 output full, bit 1 input full, bit 3 command flag, and bits 2 and 4 to 7 software-owned, with bit 5 serving as the auxiliary output-full flag.
- R5: `mc_ib_rd` clears status bit 1. If a host write happens in the same cycle, bit 1 stays set and the new byte is kept.
- R6: If a controller output write and a host data read happen in the same cycle, status bit 0 stays set and the new byte is kept.
- R7: Before enable-flags, `kbd_irq` equals control latch bit 1 and `mse_irq` equals control latch bit 2.
- R8: After `mc_en_flags`, `kbd_irq` equals status bit 0 AND latch bit 1. A host data read therefore drops it.
- R9: After `mc_en_flags`, `mse_irq` equals NOT status bit 1 AND latch bit 2.
- R10: `gate_a20` equals control latch bit 0. The latch is written by `mc_ctl_wr` with `mc_ctl_wdata`.
- R11: Status bits 2 and 4 to 7 change only through `mc_stat_wr`, which copies those bits of `mc_stat_wdata` and leaves bits 0, 1 and 3 alone. No host or buffer activity clears the auxiliary flag in bit 5.
- R12: Reset clears the status register, both buffers and enable-flags mode. It loads the control latch with 3'b001, so `kbd_irq`=0, `mse_irq`=0 and `gate_a20`=1.
- R13: A host read or write strobe while `hst_cs`=0 has no effect on any buffer, flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cs | input | 1 | Host chip select |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 1 | Host address bit: 0 data, 1 command/status |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data, registered |
| mc_ib_rd | input | 1 | Controller takes the input buffer |
| mc_ib_data | output | DATA_W | Input buffer contents |
| mc_ob_wr | input | 1 | Controller writes the output buffer |
| mc_ob_wdata | input | DATA_W | Output buffer write data |
| mc_stat_wr | input | 1 | Controller writes software-owned status bits |
| mc_stat_wdata | input | DATA_W | Status write data |
| mc_en_flags | input | 1 | Enable-flags command pulse |
| mc_ctl_wr | input | 1 | Control latch write |
| mc_ctl_wdata | input | 3 | Latch: bit 0 gate, bit 1 keyboard irq, bit 2 mouse irq |
| mc_status | output | DATA_W | Status register as seen by the controller |
| kbd_irq | output | 1 | Keyboard interrupt |
| mse_irq | output | 1 | Mouse interrupt |
| gate_a20 | output | 1 | Address-line-20 gate |

## Verification
The assertions assume that the host never raises read and write in the same cycle. They also assume the build keeps the default combinational interrupt path, since the interrupt properties are written for zero added latency. The stimulus only ever picks one host strobe per step, and it uses chip select set to 0 only to show that the strobes are ignored. Same-cycle collisions between host and controller activity are allowed and are produced on purpose, both directed and by random draws.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
   // status register bit positions (the host driver decodes these)
   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_CMD = 3;
   localparam int ST_AUX = 5;
   // bits owned by hardware; all others belong to controller software
   localparam logic [7:0] ST_HW_MASK = 8'h0B;
   // control latch bit positions
   localparam int CTL_GATE = 0;
   localparam int CTL_KIRQ = 1;
   localparam int CTL_MIRQ = 2;
   localparam int CTL_W    = 3;
endpackage

// File: rtl/kbm_host_if.sv
module kbm_host_if #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic              addr,
   input  logic [DATA_W-1:0] status,
   input  logic [DATA_W-1:0] obuf,
   output logic              wr_any,
   output logic              wr_cmd,
   output logic              rd_data,
   output logic [DATA_W-1:0] rdata
);
   logic rd_any;

   assign wr_any  = cs & wr;
   assign wr_cmd  = addr;
   assign rd_any  = cs & rd;
   assign rd_data = rd_any & ~addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_any)
         rdata <= addr ? status : obuf;
   end
endmodule

// File: rtl/kbm_buffers.sv
module kbm_buffers #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr,
   input  logic              h_cmd,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              h_rd_data,
   input  logic              c_ib_rd,
   input  logic              c_ob_wr,
   input  logic [DATA_W-1:0] c_ob_wdata,
   input  logic              c_stat_wr,
   input  logic [DATA_W-1:0] c_stat_wdata,
   input  logic              c_en_flags,
   output logic [DATA_W-1:0] ibuf,
   output logic [DATA_W-1:0] obuf,
   output logic [DATA_W-1:0] status,
   output logic              obf,
   output logic              ibf,
   output logic              flags_en
);
   import kbm_pkg::*;

   localparam logic [DATA_W-1:0] SW_MASK = ~DATA_W'(ST_HW_MASK);

   logic              cmd_q;
   logic [DATA_W-1:0] sw_q;

   // input buffer side: a host write wins over a controller read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibuf  <= '0;
         ibf   <= 1'b0;
         cmd_q <= 1'b0;
      end else if (h_wr) begin
         ibuf  <= h_wdata;
         ibf   <= 1'b1;
         cmd_q <= h_cmd;
      end else if (c_ib_rd) begin
         ibf   <= 1'b0;
      end
   end

   // output buffer side: a controller write wins over a host read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obuf <= '0;
         obf  <= 1'b0;
      end else if (c_ob_wr) begin
         obuf <= c_ob_wdata;
         obf  <= 1'b1;
      end else if (h_rd_data) begin
         obf  <= 1'b0;
      end
   end

   // software-owned status bits, including the auxiliary output flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sw_q <= '0;
      else if (c_stat_wr)
         sw_q <= (sw_q & ~SW_MASK) | (c_stat_wdata & SW_MASK);
   end

   // enable-flags mode is sticky until reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_en <= 1'b0;
      else if (c_en_flags)
         flags_en <= 1'b1;
   end

   always_comb begin
      status         = sw_q & SW_MASK;
      status[ST_OBF] = obf;
      status[ST_IBF] = ibf;
      status[ST_CMD] = cmd_q;
   end
endmodule

// File: rtl/kbm_ctl_latch.sv
module kbm_ctl_latch #(
   parameter logic [kbm_pkg::CTL_W-1:0] RST_VAL = 3'b001
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [kbm_pkg::CTL_W-1:0] wdata,
   output logic                      gate,
   output logic                      kirq_lvl,
   output logic                      mirq_lvl
);
   import kbm_pkg::*;

   logic [CTL_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= RST_VAL;
      else if (wr)
         ctl_q <= wdata;
   end

   assign gate     = ctl_q[CTL_GATE];
   assign kirq_lvl = ctl_q[CTL_KIRQ];
   assign mirq_lvl = ctl_q[CTL_MIRQ];
endmodule

// File: rtl/kbm_irq_gen.sv
module kbm_irq_gen #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flags_en,
   input  logic obf,
   input  logic ibf,
   input  logic kirq_lvl,
   input  logic mirq_lvl,
   output logic kbd_irq,
   output logic mse_irq
);
   logic k_nxt, m_nxt;

   always_comb begin
      if (flags_en) begin
         k_nxt = obf & kirq_lvl;
         m_nxt = ~ibf & mirq_lvl;
      end else begin
         k_nxt = kirq_lvl;
         m_nxt = mirq_lvl;
      end
   end

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            kbd_irq <= 1'b0;
            mse_irq <= 1'b0;
         end else begin
            kbd_irq <= k_nxt;
            mse_irq <= m_nxt;
         end
      end
   end else begin : g_comb
      assign kbd_irq = k_nxt;
      assign mse_irq = m_nxt;
   end
endmodule

// File: rtl/kbd_host_mailbox.sv
module kbd_host_mailbox #(
   parameter int                        DATA_W  = 8,
   parameter bit                        IRQ_REG = 1'b0,
   parameter logic [kbm_pkg::CTL_W-1:0] CTL_RST = 3'b001
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      hst_cs,
   input  logic                      hst_rd,
   input  logic                      hst_wr,
   input  logic                      hst_addr,
   input  logic [DATA_W-1:0]         hst_wdata,
   output logic [DATA_W-1:0]         hst_rdata,
   input  logic                      mc_ib_rd,
   output logic [DATA_W-1:0]         mc_ib_data,
   input  logic                      mc_ob_wr,
   input  logic [DATA_W-1:0]         mc_ob_wdata,
   input  logic                      mc_stat_wr,
   input  logic [DATA_W-1:0]         mc_stat_wdata,
   input  logic                      mc_en_flags,
   input  logic                      mc_ctl_wr,
   input  logic [kbm_pkg::CTL_W-1:0] mc_ctl_wdata,
   output logic [DATA_W-1:0]         mc_status,
   output logic                      kbd_irq,
   output logic                      mse_irq,
   output logic                      gate_a20
);
   if (DATA_W < 8) begin : g_bad_width
      $error("kbd_host_mailbox: DATA_W must be at least 8");
   end
   if (CTL_RST[kbm_pkg::CTL_KIRQ] != 1'b0) begin : g_bad_rst
      $error("kbd_host_mailbox: keyboard irq level must reset to 0");
   end

   logic              h_wr, h_cmd, h_rd_data;
   logic [DATA_W-1:0] obuf, status;
   logic              obf, ibf, flags_en;
   logic              kirq_lvl, mirq_lvl;

   kbm_host_if #(.DATA_W(DATA_W)) u_host (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (hst_cs),
      .rd      (hst_rd),
      .wr      (hst_wr),
      .addr    (hst_addr),
      .status  (status),
      .obuf    (obuf),
      .wr_any  (h_wr),
      .wr_cmd  (h_cmd),
      .rd_data (h_rd_data),
      .rdata   (hst_rdata)
   );

   kbm_buffers #(.DATA_W(DATA_W)) u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .h_wr         (h_wr),
      .h_cmd        (h_cmd),
      .h_wdata      (hst_wdata),
      .h_rd_data    (h_rd_data),
      .c_ib_rd      (mc_ib_rd),
      .c_ob_wr      (mc_ob_wr),
      .c_ob_wdata   (mc_ob_wdata),
      .c_stat_wr    (mc_stat_wr),
      .c_stat_wdata (mc_stat_wdata),
      .c_en_flags   (mc_en_flags),
      .ibuf         (mc_ib_data),
      .obuf         (obuf),
      .status       (status),
      .obf          (obf),
      .ibf          (ibf),
      .flags_en     (flags_en)
   );

   kbm_ctl_latch #(.RST_VAL(CTL_RST)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (mc_ctl_wr),
      .wdata    (mc_ctl_wdata),
      .gate     (gate_a20),
      .kirq_lvl (kirq_lvl),
      .mirq_lvl (mirq_lvl)
   );

   kbm_irq_gen #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags_en (flags_en),
      .obf      (obf),
      .ibf      (ibf),
      .kirq_lvl (kirq_lvl),
      .mirq_lvl (mirq_lvl),
      .kbd_irq  (kbd_irq),
      .mse_irq  (mse_irq)
   );

   assign mc_status = status;
endmodule

// File: rtl/kbm_mailbox_chk.sv
module kbm_mailbox_chk #(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      hst_cs,
   input logic                      hst_rd,
   input logic                      hst_wr,
   input logic                      hst_addr,
   input logic [DATA_W-1:0]         hst_wdata,
   input logic                      mc_ib_rd,
   input logic [DATA_W-1:0]         mc_ib_data,
   input logic                      mc_ob_wr,
   input logic                      mc_stat_wr,
   input logic                      mc_en_flags,
   input logic                      mc_ctl_wr,
   input logic [kbm_pkg::CTL_W-1:0] mc_ctl_wdata,
   input logic [DATA_W-1:0]         mc_status,
   input logic                      kbd_irq,
   input logic                      mse_irq,
   input logic                      gate_a20
);
   import kbm_pkg::*;

   logic       hw, hrd;
   logic       en_seen;
   logic [2:0] ctl_seen;

   assign hw  = hst_cs & hst_wr;
   assign hrd = hst_cs & hst_rd & ~hst_addr;

   // independent tracking of the controller's commands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_seen  <= 1'b0;
         ctl_seen <= 3'b001;
      end else begin
         if (mc_en_flags) en_seen  <= 1'b1;
         if (mc_ctl_wr)   ctl_seen <= mc_ctl_wdata;
      end
   end

   p_ibf_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hw |=> mc_status[ST_IBF] && mc_ib_data == $past(hst_wdata));

   p_cmd_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hw |=> mc_status[ST_CMD] == $past(hst_addr));

   p_obf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mc_ob_wr |=> mc_status[ST_OBF]);

   p_obf_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hrd && !mc_ob_wr) |=> !mc_status[ST_OBF]);

   p_ibf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_ib_rd && !hw) |=> !mc_status[ST_IBF]);

   p_sw_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mc_stat_wr |=> $stable(mc_status[ST_AUX]) && $stable(mc_status[7:4])
                      && $stable(mc_status[2]));

   p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      gate_a20 == ctl_seen[CTL_GATE]);

   if (!IRQ_REG) begin : g_irq_chk
      p_kirq_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !en_seen |-> kbd_irq == ctl_seen[CTL_KIRQ] && mse_irq == ctl_seen[CTL_MIRQ]);

      p_kirq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
         en_seen |-> kbd_irq == (mc_status[ST_OBF] & ctl_seen[CTL_KIRQ]));

      p_mirq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
         en_seen |-> mse_irq == (!mc_status[ST_IBF] & ctl_seen[CTL_MIRQ]));
   end
endmodule

bind kbd_host_mailbox kbm_mailbox_chk #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hst_cs       (hst_cs),
   .hst_rd       (hst_rd),
   .hst_wr       (hst_wr),
   .hst_addr     (hst_addr),
   .hst_wdata    (hst_wdata),
   .mc_ib_rd     (mc_ib_rd),
   .mc_ib_data   (mc_ib_data),
   .mc_ob_wr     (mc_ob_wr),
   .mc_stat_wr   (mc_stat_wr),
   .mc_en_flags  (mc_en_flags),
   .mc_ctl_wr    (mc_ctl_wr),
   .mc_ctl_wdata (mc_ctl_wdata),
   .mc_status    (mc_status),
   .kbd_irq      (kbd_irq),
   .mse_irq      (mse_irq),
   .gate_a20     (gate_a20)
);

// File: tb/tb_kbd_host_mailbox.sv
module tb_kbd_host_mailbox;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_cs = 0, hst_rd = 0, hst_wr = 0, hst_addr = 0;
   logic [7:0] hst_wdata = 0, hst_rdata;
   logic       mc_ib_rd = 0, mc_ob_wr = 0, mc_stat_wr = 0, mc_en_flags = 0, mc_ctl_wr = 0;
   logic [7:0] mc_ib_data, mc_ob_wdata = 0, mc_stat_wdata = 0, mc_status;
   logic [2:0] mc_ctl_wdata = 0;
   logic       kbd_irq, mse_irq, gate_a20;

   int checks = 0;
   int errors = 0;

   // bench model
   logic       m_ibf, m_obf, m_cmd, m_en;
   logic [7:0] m_ib, m_ob, m_sw, m_rd;
   logic [2:0] m_ctl;

   always #5 clk = ~clk;

   kbd_host_mailbox dut (
      .clk(clk), .rst_n(rst_n), .hst_cs(hst_cs), .hst_rd(hst_rd), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .mc_ib_rd(mc_ib_rd), .mc_ib_data(mc_ib_data), .mc_ob_wr(mc_ob_wr),
      .mc_ob_wdata(mc_ob_wdata), .mc_stat_wr(mc_stat_wr), .mc_stat_wdata(mc_stat_wdata),
      .mc_en_flags(mc_en_flags), .mc_ctl_wr(mc_ctl_wr), .mc_ctl_wdata(mc_ctl_wdata),
      .mc_status(mc_status), .kbd_irq(kbd_irq), .mse_irq(mse_irq), .gate_a20(gate_a20));

   function automatic logic [7:0] exp_status();
      logic [7:0] s;
      s    = m_sw & 8'hF4;
      s[0] = m_obf;
      s[1] = m_ibf;
      s[3] = m_cmd;
      return s;
   endfunction

   function automatic logic exp_kirq();
      return m_en ? (m_obf & m_ctl[1]) : m_ctl[1];
   endfunction

   function automatic logic exp_mirq();
      return m_en ? (~m_ibf & m_ctl[2]) : m_ctl[2];
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic verify(string tag, logic was_rd);
      chk(tag, "status", mc_status, exp_status());
      chk(tag, "ib_data", mc_ib_data, m_ib);
      chk(tag, "kbd_irq", {7'd0, kbd_irq}, {7'd0, exp_kirq()});
      chk(tag, "mse_irq", {7'd0, mse_irq}, {7'd0, exp_mirq()});
      chk(tag, "gate_a20", {7'd0, gate_a20}, {7'd0, m_ctl[0]});
      if (was_rd) chk(tag, "rdata", hst_rdata, m_rd);
   endtask

   // one clock step with every input given; inputs change at the falling edge
   task automatic step(string tag, logic cs, logic rd, logic wr, logic a, logic [7:0] wd,
                       logic ibrd, logic obw, logic [7:0] obd, logic stw, logic [7:0] std,
                       logic en, logic cw, logic [2:0] cd);
      logic hw, hr;
      hst_cs = cs; hst_rd = rd; hst_wr = wr; hst_addr = a; hst_wdata = wd;
      mc_ib_rd = ibrd; mc_ob_wr = obw; mc_ob_wdata = obd; mc_stat_wr = stw;
      mc_stat_wdata = std; mc_en_flags = en; mc_ctl_wr = cw; mc_ctl_wdata = cd;
      @(posedge clk);
      hw = cs & wr;
      hr = cs & rd;
      if (hr) m_rd = a ? exp_status() : m_ob;
      if (hw) begin m_ib = wd; m_ibf = 1; m_cmd = a; end
      else if (ibrd) m_ibf = 0;
      if (obw) begin m_ob = obd; m_obf = 1; end
      else if (hr && !a) m_obf = 0;
      if (stw) m_sw = std;
      if (en) m_en = 1;
      if (cw) m_ctl = cd;
      @(negedge clk);
      hst_cs = 0; hst_rd = 0; hst_wr = 0; mc_ib_rd = 0; mc_ob_wr = 0;
      mc_stat_wr = 0; mc_en_flags = 0; mc_ctl_wr = 0;
      verify(tag, hr);
   endtask

   task automatic h_write(string tag, logic a, logic [7:0] d);
      step(tag, 1, 0, 1, a, d, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic h_read(string tag, logic a);
      step(tag, 1, 1, 0, a, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic c_obw(string tag, logic [7:0] d);
      step(tag, 0, 0, 0, 0, 0, 0, 1, d, 0, 0, 0, 0, 0);
   endtask
   task automatic c_ctl(string tag, logic [2:0] d);
      step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_ibf = 0; m_obf = 0; m_cmd = 0; m_en = 0;
      m_ib = 0; m_ob = 0; m_sw = 0; m_rd = 0; m_ctl = 3'b001;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R12: reset state
      verify("R12", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      verify("R12", 1'b0);

      h_write("R1", 0, 8'h5A);
      step("R5", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      h_write("R2", 1, 8'hD1);
      // R13: strobes without chip select
      step("R13", 0, 0, 1, 0, 8'h33, 0, 0, 0, 0, 0, 0, 0, 0);
      c_obw("R3", 8'hFA);
      step("R13", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R5: host write collides with controller read
      step("R5", 1, 0, 1, 0, 8'h77, 1, 0, 0, 0, 0, 0, 0, 0);
      h_read("R4", 1);
      h_read("R3", 0);
      // R7: direct interrupt control
      c_ctl("R7", 3'b011);
      c_ctl("R7", 3'b101);
      // R11: software status bits
      step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
      h_write("R11", 0, 8'h01);
      step("R11", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      h_read("R4", 1);
      // R8/R9: enable flags
      step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 3'b111);
      c_obw("R8", 8'h42);
      h_read("R8", 0);
      h_write("R9", 1, 8'hAA);
      step("R9", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      // R6: output write collides with host data read
      c_obw("R6", 8'h10);
      step("R6", 1, 1, 0, 0, 0, 0, 1, 8'h20, 0, 0, 0, 0, 0);
      h_read("R6", 0);
      c_ctl("R10", 3'b110);
      c_ctl("R10", 3'b001);
      step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] sel;
         logic       hcs;
         sel = 4'($urandom_range(0, 9));
         hcs = ($urandom_range(0, 7) != 0);
         step("RND", hcs, sel == 1 || sel == 2, sel == 0 || sel == 3,
              1'($urandom), 8'($urandom),
              ($urandom_range(0, 3) == 0), (sel == 4 || sel == 2),
              8'($urandom), (sel == 5), 8'($urandom),
              (i > 2000 && sel == 6), (sel == 7 || sel == 8), 3'($urandom));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule